// File: doc/BRIEF.md
# Bounding-Box Tile Binner

This block sorts screen-space triangles into a grid of square screen tiles. The tiles share one fixed power-of-two edge length. Vertices arrive one at a time on a valid/ready stream, and every three vertices make one isolated triangle. The block keeps the smallest and largest integer pixel x and y of the three vertices. It turns that screen-aligned box into a span of tile columns and tile rows. It then sends out one copy of the whole triangle for each tile in that span, with each copy tagged by its tile column and tile row.

The test is made against the box only, not the triangle itself. A long thin or diagonal triangle can therefore reach tiles it never covers. The grid starts at pixel (0,0). The rightmost column and the bottom row may reach past the window edge. Tiles beyond the window are never produced. Each copy carries a running copy number, and the final copy carries a marker, so a downstream consumer reads the tile overlap of the triangle from the last copy. While the copies of one triangle are being sent, the next triangle is held off at the input.

Top module: `tile_binner`

## Requirements
- R1: A vertex is taken on a clock edge where `in_valid` and `in_ready` are both high. Every three vertices taken form one triangle. Within a vertex, bits [31:0] hold x and bits [63:32] hold y. Both are unsigned fixed point with FRAC_BITS fraction bits, and the pixel coordinate is the field shifted right by FRAC_BITS. Bits [223:64] hold the other five 32-bit fields, which the block carries through unchanged.
- R2: Every copy presents on `out_tri` the three vertex records in arrival order. The first vertex is at bits [223:0], the second at [447:224] and the third at [671:448].
- R3: A triangle is placed in exactly the tiles whose columns run from minx>>TILE_LOG2 to maxx>>TILE_LOG2 and whose rows run from miny>>TILE_LOG2 to maxy>>TILE_LOG2. Here min and max are taken over the pixel coordinates of its vertices.
- R4: Column 0 and row 0 begin at pixel 0. There are ceil(WIN_W/2^TILE_LOG2) columns and ceil(WIN_H/2^TILE_LOG2) rows, so the last column or row may be partial. A box that extends beyond the window is clamped to the last existing column and row.
- R5: A triangle with minx >= WIN_W or miny >= WIN_H produces no copy. It is still consumed, and `in_ready` returns high.
- R6: The copies of one triangle appear in row-major order: columns left to right within a row, and rows top to bottom.
- R7: `out_count` gives the 1-based number of the current copy. `out_last` is high only on the final copy, so that copy's `out_count` equals the number of tiles the box overlaps.
- R8: `in_ready` stays low from the edge that takes the third vertex until the final copy has been accepted, or until an empty triangle (R5) has been dropped.
- R9: While `out_valid` is high and `out_ready` is low, all outputs hold steady. Each tile is delivered exactly once, and `out_valid` falls after the final copy is accepted.
- R10: After a synchronous active-low reset, `out_valid` is low and `in_ready` is high. The next vertex taken is the first vertex of a new triangle, even if reset came in the middle of a triangle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Vertex available |
| in_ready | output | 1 | Block can take a vertex |
| in_vtx | input | 224 | Vertex record: x, y, then five carried fields |
| out_valid | output | 1 | Tile copy available |
| out_ready | input | 1 | Downstream takes the copy |
| out_tri | output | 672 | Three vertex records of the triangle |
| out_col | output | COL_W | Tile column of this copy |
| out_row | output | ROW_W | Tile row of this copy |
| out_count | output | CNT_W | 1-based copy number; the tile overlap on the last copy |
| out_last | output | 1 | Final copy of this triangle |

## Verification
The hardest condition to reach is downstream stall combined with a multi-row walk. In that case the column counter must wrap back to the first column and the row counter must advance while the same copy is held. The stimulus table runs every other triangle with an `out_ready` pattern that drops for one cycle in three, and the bench checks that held outputs stay the same. Boxes that cross a tile edge by one pixel, boxes clamped at the window edge, and boxes wholly outside the window are all in the table, with fraction bits set so that truncation to whole pixels is exercised. A separate test resets the block in the middle of a triangle.

// File: rtl/tbin_pkg.sv
// Shared widths and types of the tile binner.
// Assumes 32-bit vertex fields, seven per vertex, three vertices per triangle.
package tbin_pkg;
    localparam int FIELD_W    = 32;
    localparam int VTX_FIELDS = 7;
    localparam int VTX_W      = FIELD_W * VTX_FIELDS;
    localparam int TRI_VTX    = 3;
    localparam int TRI_W      = VTX_W * TRI_VTX;

    typedef enum logic {
        W_IDLE = 1'b0,
        W_EMIT = 1'b1
    } walk_state_t;
endpackage

// File: rtl/tbin_gather.sv
// Collects three vertices into one triangle record and keeps a running
// pixel bounding box. Holds the triangle (tri_full) until the walker
// releases it. Assumes x and y are unsigned fixed point with FRAC_BITS
// fraction bits in the two lowest fields of a vertex.
module tbin_gather
    import tbin_pkg::*;
#(
    parameter int FRAC_BITS = 4,
    localparam int PIX_W = FIELD_W - FRAC_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [VTX_W-1:0] in_vtx,
    input  logic             release_i,
    output logic             tri_full,
    output logic [TRI_W-1:0] tri_data,
    output logic [PIX_W-1:0] min_x,
    output logic [PIX_W-1:0] max_x,
    output logic [PIX_W-1:0] min_y,
    output logic [PIX_W-1:0] max_y
);
    logic [1:0]       vidx;
    logic [PIX_W-1:0] px, py;
    logic             take;

    // Pixel coordinates of the incoming vertex.
    always_comb begin
        px = in_vtx[FRAC_BITS +: PIX_W];
        py = in_vtx[FIELD_W + FRAC_BITS +: PIX_W];
    end

    assign in_ready = !tri_full;
    assign take     = in_valid && in_ready;

    // Vertex slot index and triangle-held flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vidx     <= 2'd0;
            tri_full <= 1'b0;
        end else if (release_i) begin
            tri_full <= 1'b0;
        end else if (take) begin
            if (vidx == 2'd2) begin
                vidx     <= 2'd0;
                tri_full <= 1'b1;
            end else begin
                vidx <= vidx + 2'd1;
            end
        end
    end

    // Store the vertex record and widen the bounding box.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tri_data <= '0;
            min_x    <= '0;
            max_x    <= '0;
            min_y    <= '0;
            max_y    <= '0;
        end else if (take) begin
            tri_data[vidx*VTX_W +: VTX_W] <= in_vtx;
            if (vidx == 2'd0) begin
                min_x <= px;
                max_x <= px;
                min_y <= py;
                max_y <= py;
            end else begin
                if (px < min_x) min_x <= px;
                if (px > max_x) max_x <= px;
                if (py < min_y) min_y <= py;
                if (py > max_y) max_y <= py;
            end
        end
    end

    // R8: a held triangle stays held until the walker releases it.
    a_r8_hold_until_release: assert property (@(posedge clk) disable iff (!rst_n)
        tri_full && !release_i |=> tri_full);

    // R1: the box is ordered once a triangle is complete.
    a_r1_box_ordered: assert property (@(posedge clk) disable iff (!rst_n)
        tri_full |-> (min_x <= max_x) && (min_y <= max_y));
endmodule

// File: rtl/tbin_range.sv
// Converts a pixel bounding box into an inclusive span of tile columns and
// rows. The grid is anchored at pixel 0 and clamped to the window; flags a
// box that starts beyond the window. Purely combinational.
module tbin_range #(
    parameter int PIX_W     = 28,
    parameter int TILE_LOG2 = 5,
    parameter int WIN_W     = 640,
    parameter int WIN_H     = 480,
    parameter int COL_W     = 5,
    parameter int ROW_W     = 4
) (
    input  logic [PIX_W-1:0] min_x,
    input  logic [PIX_W-1:0] max_x,
    input  logic [PIX_W-1:0] min_y,
    input  logic [PIX_W-1:0] max_y,
    output logic [COL_W-1:0] col_lo,
    output logic [COL_W-1:0] col_hi,
    output logic [ROW_W-1:0] row_lo,
    output logic [ROW_W-1:0] row_hi,
    output logic             empty
);
    localparam logic [PIX_W-1:0] X_LAST = PIX_W'(WIN_W - 1);
    localparam logic [PIX_W-1:0] Y_LAST = PIX_W'(WIN_H - 1);

    logic [PIX_W-1:0] x_hi_cl, y_hi_cl;

    // Clamp the far corner to the window, then shift down to tile units.
    always_comb begin
        x_hi_cl = (max_x > X_LAST) ? X_LAST : max_x;
        y_hi_cl = (max_y > Y_LAST) ? Y_LAST : max_y;
        empty   = (min_x > X_LAST) || (min_y > Y_LAST);
        col_lo  = COL_W'(min_x >> TILE_LOG2);
        col_hi  = COL_W'(x_hi_cl >> TILE_LOG2);
        row_lo  = ROW_W'(min_y >> TILE_LOG2);
        row_hi  = ROW_W'(y_hi_cl >> TILE_LOG2);
    end
endmodule

// File: rtl/tbin_walker.sv
// Walks a tile span in row-major order and presents one copy per tile on a
// valid/ready port, numbering the copies and marking the last. Releases the
// held triangle after the last copy is accepted, or at once if it is empty.
module tbin_walker
    import tbin_pkg::*;
#(
    parameter int COL_W = 5,
    parameter int ROW_W = 4,
    parameter int CNT_W = 9,
    parameter int NCOLS = 20,
    parameter int NROWS = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tri_full,
    input  logic             empty,
    input  logic [COL_W-1:0] col_lo,
    input  logic [COL_W-1:0] col_hi,
    input  logic [ROW_W-1:0] row_lo,
    input  logic [ROW_W-1:0] row_hi,
    output logic             release_o,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [COL_W-1:0] out_col,
    output logic [ROW_W-1:0] out_row,
    output logic [CNT_W-1:0] out_count,
    output logic             out_last
);
    walk_state_t      st;
    logic [COL_W-1:0] c_first, c_end;
    logic [ROW_W-1:0] r_end;

    assign out_valid = (st == W_EMIT);
    assign out_last  = (out_col == c_end) && (out_row == r_end);
    assign release_o = ((st == W_IDLE) && tri_full && empty)
                     || ((st == W_EMIT) && out_ready && out_last);

    // Load the span, then step the tile position on each accepted copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= W_IDLE;
            out_col   <= '0;
            out_row   <= '0;
            out_count <= '0;
            c_first   <= '0;
            c_end     <= '0;
            r_end     <= '0;
        end else begin
            case (st)
                W_IDLE: begin
                    if (tri_full && !empty) begin
                        out_col   <= col_lo;
                        out_row   <= row_lo;
                        c_first   <= col_lo;
                        c_end     <= col_hi;
                        r_end     <= row_hi;
                        out_count <= CNT_W'(1);
                        st        <= W_EMIT;
                    end
                end
                W_EMIT: begin
                    if (out_ready) begin
                        if (out_last) begin
                            st <= W_IDLE;
                        end else begin
                            if (out_col == c_end) begin
                                out_col <= c_first;
                                out_row <= out_row + ROW_W'(1);
                            end else begin
                                out_col <= out_col + COL_W'(1);
                            end
                            out_count <= out_count + CNT_W'(1);
                        end
                    end
                end
                default: st <= W_IDLE;
            endcase
        end
    end

    // R9: a stalled copy keeps its tag and number.
    a_r9_stall_stable: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_col)
            && $stable(out_row) && $stable(out_count));

    // R8: copies only exist while the gatherer holds a triangle.
    a_r8_copy_needs_triangle: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> tri_full);

    // R4: every tag names a tile inside the grid.
    a_r4_tile_in_grid: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(out_col) < NCOLS) && (int'(out_row) < NROWS));

    // R7: copy numbers rise by one across a walk.
    a_r7_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && !out_last |=> out_valid
            && (out_count == $past(out_count) + CNT_W'(1)));

    // R9: the walk ends after its final copy is taken.
    a_r9_ends_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_last |=> !out_valid);
endmodule

// File: rtl/tile_binner.sv
// Top of the bounding-box tile binner: gatherer, range converter and tile
// walker. TILE_LOG2 selects a tile edge of 16 to 256 pixels (4 to 8).
module tile_binner
    import tbin_pkg::*;
#(
    parameter int TILE_LOG2 = 5,
    parameter int WIN_W     = 640,
    parameter int WIN_H     = 480,
    parameter int FRAC_BITS = 4,
    localparam int TILE  = 1 << TILE_LOG2,
    localparam int NCOLS = (WIN_W + TILE - 1) / TILE,
    localparam int NROWS = (WIN_H + TILE - 1) / TILE,
    localparam int COL_W = $clog2(NCOLS + 1),
    localparam int ROW_W = $clog2(NROWS + 1),
    localparam int CNT_W = $clog2(NCOLS * NROWS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [VTX_W-1:0] in_vtx,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [TRI_W-1:0] out_tri,
    output logic [COL_W-1:0] out_col,
    output logic [ROW_W-1:0] out_row,
    output logic [CNT_W-1:0] out_count,
    output logic             out_last
);
    localparam int PIX_W = FIELD_W - FRAC_BITS;

    logic             tri_full, release_w, empty;
    logic [PIX_W-1:0] min_x, max_x, min_y, max_y;
    logic [COL_W-1:0] col_lo, col_hi;
    logic [ROW_W-1:0] row_lo, row_hi;

    tbin_gather #(.FRAC_BITS(FRAC_BITS)) u_gather (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_vtx(in_vtx),
        .release_i(release_w), .tri_full(tri_full), .tri_data(out_tri),
        .min_x(min_x), .max_x(max_x), .min_y(min_y), .max_y(max_y)
    );

    tbin_range #(
        .PIX_W(PIX_W), .TILE_LOG2(TILE_LOG2), .WIN_W(WIN_W), .WIN_H(WIN_H),
        .COL_W(COL_W), .ROW_W(ROW_W)
    ) u_range (
        .min_x(min_x), .max_x(max_x), .min_y(min_y), .max_y(max_y),
        .col_lo(col_lo), .col_hi(col_hi), .row_lo(row_lo), .row_hi(row_hi),
        .empty(empty)
    );

    tbin_walker #(
        .COL_W(COL_W), .ROW_W(ROW_W), .CNT_W(CNT_W),
        .NCOLS(NCOLS), .NROWS(NROWS)
    ) u_walker (
        .clk(clk), .rst_n(rst_n),
        .tri_full(tri_full), .empty(empty),
        .col_lo(col_lo), .col_hi(col_hi), .row_lo(row_lo), .row_hi(row_hi),
        .release_o(release_w),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_col(out_col), .out_row(out_row),
        .out_count(out_count), .out_last(out_last)
    );
endmodule

// File: tb/tile_binner_bench.sv
// Self-checking bench: table of triangles with expected tile spans, then
// directed reset tests.
module tile_binner_bench;
    import tbin_pkg::*;

    localparam int TILE_LOG2 = 5;
    localparam int WIN_W     = 100;
    localparam int WIN_H     = 70;
    localparam int FRAC_BITS = 4;
    localparam int TILE  = 1 << TILE_LOG2;
    localparam int NCOLS = (WIN_W + TILE - 1) / TILE;
    localparam int NROWS = (WIN_H + TILE - 1) / TILE;
    localparam int COL_W = $clog2(NCOLS + 1);
    localparam int ROW_W = $clog2(NROWS + 1);
    localparam int CNT_W = $clog2(NCOLS * NROWS + 1);

    // x0,y0,x1,y1,x2,y2 pixels; expected col lo/hi, row lo/hi; copies (0 = none)
    localparam int NV = 10;
    localparam int TV [NV][11] = '{
        '{  5,  5,  20, 10, 10,  25,  0, 0, 0, 0,  1 },
        '{ 30,  5,  40, 40, 10,  20,  0, 1, 0, 1,  4 },
        '{  0, 33,  99, 34, 50,  35,  0, 3, 1, 1,  4 },
        '{ 65,  0,  66, 69, 64,  30,  2, 2, 0, 2,  3 },
        '{ 90, 60, 300,200, 95,  65,  2, 3, 1, 2,  4 },
        '{200, 10, 210, 20,205,  15,  0, 0, 0, 0,  0 },
        '{ 31,  0,  32,  0, 31,  31,  0, 1, 0, 0,  2 },
        '{ 10, 80,  20, 90, 15,  85,  0, 0, 0, 0,  0 },
        '{  0,  0,  99,  0,  0,  69,  0, 3, 0, 2, 12 },
        '{ 99, 69,  99, 69, 99,  69,  3, 3, 2, 2,  1 }
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [VTX_W-1:0] in_vtx = '0;
    logic             out_valid;
    logic             out_ready = 1'b0;
    logic [TRI_W-1:0] out_tri;
    logic [COL_W-1:0] out_col;
    logic [ROW_W-1:0] out_row;
    logic [CNT_W-1:0] out_count;
    logic             out_last;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    tile_binner #(
        .TILE_LOG2(TILE_LOG2), .WIN_W(WIN_W), .WIN_H(WIN_H), .FRAC_BITS(FRAC_BITS)
    ) u_tile_binner (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_vtx(in_vtx),
        .out_valid(out_valid), .out_ready(out_ready), .out_tri(out_tri),
        .out_col(out_col), .out_row(out_row),
        .out_count(out_count), .out_last(out_last)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [VTX_W-1:0] mk_vtx(int t, int k, int px, int py);
        logic [VTX_W-1:0] v;
        v[31:0]    = (32'(px) << FRAC_BITS) | 32'((t + k * 5) & 15);
        v[63:32]   = (32'(py) << FRAC_BITS) | 32'((t * 3 + k) & 15);
        v[95:64]   = 32'hA000_0000 + 32'(t * 16 + k);
        v[127:96]  = 32'hB100_0000 + 32'(t * 16 + k);
        v[159:128] = 32'hC200_0000 + 32'(t * 16 + k);
        v[191:160] = 32'hD300_0000 + 32'(t * 16 + k);
        v[223:192] = 32'hE400_0000 + 32'(t * 16 + k);
        return v;
    endfunction

    task automatic send_vtx(input logic [VTX_W-1:0] v);
        int guard = 0;
        @(negedge clk);
        in_valid = 1'b1;
        in_vtx   = v;
        while (!in_ready && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    // Sends one triangle and checks every copy it produces.
    task automatic run_tri(input int t, input bit stall);
        logic [TRI_W-1:0] exp_tri;
        int n, ord;
        bit held;
        logic [COL_W-1:0] h_col;
        logic [ROW_W-1:0] h_row;
        logic [CNT_W-1:0] h_cnt;
        for (int k = 0; k < 3; k++)
            exp_tri[k*VTX_W +: VTX_W] = mk_vtx(t, k, TV[t][2*k], TV[t][2*k+1]);
        for (int k = 0; k < 3; k++)
            send_vtx(exp_tri[k*VTX_W +: VTX_W]);
        n   = TV[t][10];
        ord = 0;
        if (n == 0) begin
            // R5: nothing comes out and the triangle is consumed
            for (int w = 0; w < 4; w++) begin
                @(negedge clk);
                check(!out_valid, "R5", "no copy for off-window box", out_valid, 0);
            end
            check(in_ready, "R5", "input free after drop", in_ready, 1);
            return;
        end
        held = 1'b0;
        for (int r = TV[t][8]; r <= TV[t][9]; r++) begin
            for (int c = TV[t][6]; c <= TV[t][7]; c++) begin
                int guard = 0;
                ord++;
                forever begin
                    @(negedge clk);
                    if (held) begin
                        check(out_valid && out_col == h_col && out_row == h_row
                              && out_count == h_cnt, "R9", "stalled copy held",
                              out_count, h_cnt);
                    end
                    out_ready = stall ? ((cyc % 3) != 0) : 1'b1;
                    if (out_valid) begin
                        check(!in_ready, "R8", "input blocked during walk", in_ready, 0);
                    end
                    held  = out_valid && !out_ready;
                    h_col = out_col;
                    h_row = out_row;
                    h_cnt = out_count;
                    if (out_valid && out_ready) break;
                    guard++;
                    if (guard > 1000) begin
                        check(1'b0, "R9", "copy timeout", 0, 1);
                        return;
                    end
                end
                check(int'(out_col) == c, "R3", "tile column (R6 order)", out_col, c);
                check(int'(out_row) == r, "R4", "tile row (R6 order)", out_row, r);
                check(int'(out_count) == ord, "R7", "copy number", out_count, ord);
                check(out_last == (ord == n), "R7", "last marker", out_last, ord == n);
                tests++;
                if (out_tri !== exp_tri) begin
                    fails++;
                    $display("FAIL R2 triangle record: actual %h expected %h",
                             out_tri, exp_tri);
                end
            end
        end
        @(negedge clk);
        out_ready = 1'b0;
        check(!out_valid, "R9", "no extra copy after last", out_valid, 0);
        check(in_ready, "R8", "input free after last copy", in_ready, 1);
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid, "R10", "out_valid after reset", out_valid, 0);
        check(in_ready, "R10", "in_ready after reset", in_ready, 1);

        // Table walk; odd triangles see downstream stalls (R9).
        for (int t = 0; t < NV; t++) run_tri(t, (t % 2) == 1);

        // R10: reset in the middle of a triangle restarts at vertex 0.
        send_vtx(mk_vtx(9, 0, 99, 69));
        send_vtx(mk_vtx(9, 1, 99, 69));
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && in_ready, "R10", "idle after mid-triangle reset",
              out_valid, 0);
        run_tri(1, 1'b0);

        // R1: two partial vertices alone produce nothing.
        send_vtx(mk_vtx(0, 0, 5, 5));
        send_vtx(mk_vtx(0, 1, 20, 10));
        repeat (3) begin
            @(negedge clk);
            check(!out_valid && in_ready, "R1", "no copy before third vertex",
                  out_valid, 0);
        end
        send_vtx(mk_vtx(0, 2, 10, 25));
        repeat (2) @(negedge clk);
        check(out_valid && out_col == '0 && out_row == '0 && out_last,
              "R1", "third vertex completes triangle", out_valid, 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule